// File: doc/BRIEF.md
# Process-Tagged Translation Lookaside Buffer

This block is a small, fully associative store of recent virtual-to-physical page translations. A lookup supplies a virtual page number, a process identifier, a read/write flag and a page offset. When a valid entry carries the same page number and the same process identifier, the block returns the physical address in the same cycle. That address is the cached frame number followed by the untouched offset. Tagging entries with the process identifier lets two processes use the same virtual page number without colliding, so a context switch does not force a full flush.

A lookup that finds no entry raises a refill request to an external table walker. The walker later installs the returned mapping through the fill port. The replacement choice prefers an entry that already holds the same tag, then the lowest free slot. After that it takes an entry whose reference bit is clear, searched from a rotating pointer. Each entry holds a reference bit and a modified bit for the operating system's approximate-LRU and write-back policies. Both bits are reported on every hit. A single-cycle input clears every reference bit. Flushing removes either every entry or only the entries of one process.

Top module: `ptag_tlb`

## Requirements
- R1: A lookup hits (`lk_hit`=1 in the same cycle) only when a valid entry matches both `lk_vpn` and `lk_pid`; the same page number under another process identifier misses.
- R2: On a hit, `lk_paddr` equals the entry's frame number in the upper bits concatenated with `lk_off` in the low OFF_W bits.
- R3: A lookup with no usable match drives `miss_req`=1 and `lk_hit`=0 in the same cycle; `miss_req` is never high together with `lk_hit`.
- R4: On a hit, `lk_ref` shows the entry's reference bit as it was before this access, and the hit sets that bit from the next cycle on.
- R5: A pulse on `clr_ref` clears the reference bit of every entry at that clock edge.
- R6: On a hit, `lk_mod` shows the entry's modified bit before this access; a write hit sets the bit, a read hit leaves it unchanged.
- R7: A write lookup that matches an entry whose writable flag is 0 gives `lk_fault`=1, `lk_hit`=0 and `miss_req`=0, and changes neither the reference nor the modified bit of that entry.
- R8: A fill whose tag is already present overwrites that entry in place; otherwise it takes the lowest-numbered invalid entry. A filled entry starts with reference and modified bits clear.
- R9: When every entry is valid and the tag is new, the fill takes the first entry with a clear reference bit, searching upward from a rotating pointer with wrap-around; if all reference bits are set, it takes the pointer's entry. In both cases the pointer then moves to the entry after the victim.
- R10: `flush_valid` with `flush_all`=1 invalidates every entry; with `flush_all`=0 it invalidates only entries whose process identifier equals `flush_pid`.
- R11: When a fill and a lookup present the same page number and process identifier in the same cycle, the lookup reports a miss, and the new entry hits from the next cycle.
- R12: After synchronous reset every entry is invalid and the rotating pointer is at entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request present |
| lk_vpn | input | VPN_W (36) | Virtual page number to translate |
| lk_pid | input | PID_W (8) | Process identifier of the lookup |
| lk_write | input | 1 | 1 = write access, 0 = read access |
| lk_off | input | OFF_W (12) | Page offset, passed through |
| lk_hit | output | 1 | Translation found and permitted |
| lk_fault | output | 1 | Write to a non-writable page |
| lk_paddr | output | PFN_W+OFF_W (40) | Physical address on hit |
| lk_ref | output | 1 | Entry reference bit before this access |
| lk_mod | output | 1 | Entry modified bit before this access |
| miss_req | output | 1 | Refill request to the table walker |
| fill_valid | input | 1 | Install a mapping this cycle |
| fill_vpn | input | VPN_W (36) | Page number of the new mapping |
| fill_pid | input | PID_W (8) | Process identifier of the new mapping |
| fill_pfn | input | PFN_W (28) | Frame number of the new mapping |
| fill_wr_ok | input | 1 | Writable flag of the new mapping |
| clr_ref | input | 1 | Clear all reference bits |
| flush_valid | input | 1 | Perform a flush this cycle |
| flush_all | input | 1 | 1 = flush everything, 0 = flush one process |
| flush_pid | input | PID_W (8) | Process identifier to flush |

## Verification
The lookup outputs (`lk_hit`, `lk_fault`, `lk_paddr`, `lk_ref`, `lk_mod`, `miss_req`) are combinational and fall due in the same cycle as the request. The bench drives each request just after a falling edge and samples one nanosecond later, before the next rising edge. Fills, flushes, reference clears and the bit updates a hit makes take effect at the following rising edge, so their effect is first due on the next cycle's lookup. The bench always checks them with a separate, later lookup, which never shares a cycle with the operation that caused the change. Victim choice is not visible directly. The bench therefore predicts which tag each fill evicts from the fill order and the reference history, and then probes the evicted and surviving tags.

// File: rtl/ptag_tlb_pkg.sv
`timescale 1ns/1ps
package ptag_tlb_pkg;

    localparam int unsigned DEF_ENTRIES = 16;
    localparam int unsigned DEF_VPN_W   = 36;
    localparam int unsigned DEF_PID_W   = 8;
    localparam int unsigned DEF_PFN_W   = 28;
    localparam int unsigned DEF_OFF_W   = 12;

    // Where a fill's victim came from
    typedef enum logic [1:0] {
        VS_MATCH = 2'd0,   // same tag already present
        VS_FREE  = 2'd1,   // lowest invalid slot
        VS_CLEAN = 2'd2,   // first clear reference bit from pointer
        VS_PTR   = 2'd3    // all referenced: pointer slot
    } vsrc_e;

    // Lookup outcome carried as one bundle
    typedef struct packed {
        logic hit;
        logic fault;
        logic miss;
    } lk_res_t;

    function automatic int unsigned wrap_add(input int unsigned a,
                                             input int unsigned b,
                                             input int unsigned n);
        return (a + b) % n;
    endfunction

endpackage

// File: rtl/ptag_tlb_match.sv
`timescale 1ns/1ps
module ptag_tlb_match #(
    parameter int unsigned N     = 16,
    parameter int unsigned VPN_W = 36,
    parameter int unsigned PID_W = 8,
    localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     valid_i,
    input  logic [VPN_W-1:0] vpn_i [N],
    input  logic [PID_W-1:0] pid_i [N],
    input  logic [VPN_W-1:0] key_vpn,
    input  logic [PID_W-1:0] key_pid,
    output logic [N-1:0]     match_o,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match_o[g] = valid_i[g] && (vpn_i[g] == key_vpn) && (pid_i[g] == key_pid);
    end

    assign any_o = |match_o;

    always_comb begin
        idx_o = '0;
        for (int i = 0; i < N; i++) begin
            if (match_o[i]) idx_o = IDX_W'(i);
        end
    end

endmodule

// File: rtl/ptag_tlb_victim.sv
`timescale 1ns/1ps
module ptag_tlb_victim
    import ptag_tlb_pkg::*;
#(
    parameter int unsigned N = 16,
    localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fill_en,
    input  logic [N-1:0]     valid_i,
    input  logic [N-1:0]     ref_i,
    input  logic             same_any,
    input  logic [IDX_W-1:0] same_idx,
    output logic [IDX_W-1:0] victim_o,
    output vsrc_e            src_o
);

    logic [IDX_W-1:0] ptr_q;
    logic             free_any, clean_any;
    logic [IDX_W-1:0] free_idx, clean_idx;

    // lowest invalid slot
    always_comb begin
        free_any = 1'b0;
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid_i[i]) begin
                free_any = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
    end

    // first clear reference bit at or after the pointer, wrapping
    always_comb begin
        clean_any = 1'b0;
        clean_idx = '0;
        for (int k = N - 1; k >= 0; k--) begin
            int unsigned j;
            j = wrap_add(int'(ptr_q), k, N);
            if (!ref_i[j]) begin
                clean_any = 1'b1;
                clean_idx = IDX_W'(j);
            end
        end
    end

    always_comb begin
        if (same_any) begin
            src_o    = VS_MATCH;
            victim_o = same_idx;
        end else if (free_any) begin
            src_o    = VS_FREE;
            victim_o = free_idx;
        end else if (clean_any) begin
            src_o    = VS_CLEAN;
            victim_o = clean_idx;
        end else begin
            src_o    = VS_PTR;
            victim_o = ptr_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (fill_en && (src_o == VS_CLEAN || src_o == VS_PTR)) begin
            ptr_q <= IDX_W'(wrap_add(int'(victim_o), 1, N));
        end
    end

    AST_VICTIM_IS_FREE: assert property (@(posedge clk) disable iff (rst)
        (fill_en && !same_any && !(&valid_i)) |-> !valid_i[victim_o]) // R8
        else $error("victim is not a free slot");

    AST_PTR_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !fill_en |=> $stable(ptr_q)) // R9
        else $error("pointer moved without a fill");

    AST_PTR_RESET: assert property (@(posedge clk)
        rst |=> (ptr_q == '0)) // R12
        else $error("pointer not cleared by reset");

endmodule

// File: rtl/ptag_tlb.sv
`timescale 1ns/1ps
module ptag_tlb
    import ptag_tlb_pkg::*;
#(
    parameter int unsigned ENTRIES = DEF_ENTRIES,
    parameter int unsigned VPN_W   = DEF_VPN_W,
    parameter int unsigned PID_W   = DEF_PID_W,
    parameter int unsigned PFN_W   = DEF_PFN_W,
    parameter int unsigned OFF_W   = DEF_OFF_W,
    localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
    localparam int unsigned PA_W   = PFN_W + OFF_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lk_valid,
    input  logic [VPN_W-1:0] lk_vpn,
    input  logic [PID_W-1:0] lk_pid,
    input  logic             lk_write,
    input  logic [OFF_W-1:0] lk_off,
    output logic             lk_hit,
    output logic             lk_fault,
    output logic [PA_W-1:0]  lk_paddr,
    output logic             lk_ref,
    output logic             lk_mod,
    output logic             miss_req,
    input  logic             fill_valid,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PID_W-1:0] fill_pid,
    input  logic [PFN_W-1:0] fill_pfn,
    input  logic             fill_wr_ok,
    input  logic             clr_ref,
    input  logic             flush_valid,
    input  logic             flush_all,
    input  logic [PID_W-1:0] flush_pid
);

    // entry storage
    logic [ENTRIES-1:0] valid_q, ref_q, mod_q, wok_q;
    logic [ENTRIES-1:0] valid_d, ref_d, mod_d;
    logic [VPN_W-1:0]   vpn_q [ENTRIES];
    logic [PID_W-1:0]   pid_q [ENTRIES];
    logic [PFN_W-1:0]   pfn_q [ENTRIES];

    logic [ENTRIES-1:0] lk_match, fl_match;
    logic               lk_any, fl_any;
    logic [IDX_W-1:0]   lk_idx, fl_idx, victim;
    vsrc_e              vsrc;
    logic               collide, raw_hit;
    lk_res_t            res;

    ptag_tlb_match #(.N(ENTRIES), .VPN_W(VPN_W), .PID_W(PID_W)) u_lk_match (
        .valid_i (valid_q),
        .vpn_i   (vpn_q),
        .pid_i   (pid_q),
        .key_vpn (lk_vpn),
        .key_pid (lk_pid),
        .match_o (lk_match),
        .any_o   (lk_any),
        .idx_o   (lk_idx)
    );

    ptag_tlb_match #(.N(ENTRIES), .VPN_W(VPN_W), .PID_W(PID_W)) u_fl_match (
        .valid_i (valid_q),
        .vpn_i   (vpn_q),
        .pid_i   (pid_q),
        .key_vpn (fill_vpn),
        .key_pid (fill_pid),
        .match_o (fl_match),
        .any_o   (fl_any),
        .idx_o   (fl_idx)
    );

    ptag_tlb_victim #(.N(ENTRIES)) u_victim (
        .clk      (clk),
        .rst      (rst),
        .fill_en  (fill_valid),
        .valid_i  (valid_q),
        .ref_i    (ref_q),
        .same_any (fl_any),
        .same_idx (fl_idx),
        .victim_o (victim),
        .src_o    (vsrc)
    );

    // lookup outcome
    assign collide = fill_valid && lk_valid && (fill_vpn == lk_vpn) && (fill_pid == lk_pid);
    assign raw_hit = lk_valid && lk_any && !collide;

    always_comb begin
        res.fault = raw_hit && lk_write && !wok_q[lk_idx];
        res.hit   = raw_hit && !res.fault;
        res.miss  = lk_valid && !raw_hit;
    end

    assign lk_hit   = res.hit;
    assign lk_fault = res.fault;
    assign miss_req = res.miss;
    assign lk_paddr = {pfn_q[lk_idx], lk_off};
    assign lk_ref   = res.hit && ref_q[lk_idx];
    assign lk_mod   = res.hit && mod_q[lk_idx];

    // next state of status bits
    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            valid_d[i] = valid_q[i];
            ref_d[i]   = clr_ref ? 1'b0 : ref_q[i];
            mod_d[i]   = mod_q[i];
            if (flush_valid && (flush_all || pid_q[i] == flush_pid)) valid_d[i] = 1'b0;
            if (res.hit && lk_idx == IDX_W'(i)) begin
                ref_d[i] = 1'b1;
                if (lk_write) mod_d[i] = 1'b1;
            end
            if (fill_valid && victim == IDX_W'(i)) begin
                valid_d[i] = 1'b1;
                ref_d[i]   = 1'b0;
                mod_d[i]   = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            ref_q   <= '0;
            mod_q   <= '0;
        end else begin
            valid_q <= valid_d;
            ref_q   <= ref_d;
            mod_q   <= mod_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wok_q <= '0;
        end else if (fill_valid) begin
            wok_q[victim] <= fill_wr_ok;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_valid) begin
            vpn_q[victim] <= fill_vpn;
            pid_q[victim] <= fill_pid;
            pfn_q[victim] <= fill_pfn;
        end
    end

    AST_RESET_EMPTY: assert property (@(posedge clk)
        rst |=> (valid_q == '0)) // R12
        else $error("entries valid after reset");

    AST_HIT_NOT_MISS: assert property (@(posedge clk) disable iff (rst)
        lk_hit |-> !miss_req) // R3
        else $error("hit and miss together");

    AST_FAULT_NOT_HIT: assert property (@(posedge clk) disable iff (rst)
        lk_fault |-> (!lk_hit && !miss_req)) // R7
        else $error("fault overlaps hit or miss");

    AST_TAG_UNIQUE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lk_match)) // R8
        else $error("duplicate tag in buffer");

    AST_WRITE_MARKS: assert property (@(posedge clk) disable iff (rst)
        (lk_hit && lk_write && !fill_valid) |=> mod_q[$past(lk_idx)]) // R6
        else $error("write hit did not set modified bit");

    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (flush_valid && flush_all && !fill_valid) |=> (valid_q == '0)) // R10
        else $error("flush all left valid entries");

    AST_COLLIDE_MISS: assert property (@(posedge clk) disable iff (rst)
        collide |-> (miss_req && !lk_hit)) // R11
        else $error("same-cycle fill reported as hit");

endmodule

// File: tb/ptag_tlb_tb.sv
`timescale 1ns/1ps
module ptag_tlb_tb;

    localparam int VPN_W = 36;
    localparam int PID_W = 8;
    localparam int PFN_W = 28;
    localparam int OFF_W = 12;
    localparam int PA_W  = PFN_W + OFF_W;

    logic             clk = 1'b0;
    logic             rst;
    logic             lk_valid, lk_write;
    logic [VPN_W-1:0] lk_vpn;
    logic [PID_W-1:0] lk_pid;
    logic [OFF_W-1:0] lk_off;
    logic             lk_hit, lk_fault, lk_ref, lk_mod, miss_req;
    logic [PA_W-1:0]  lk_paddr;
    logic             fill_valid, fill_wr_ok, clr_ref, flush_valid, flush_all;
    logic [VPN_W-1:0] fill_vpn;
    logic [PID_W-1:0] fill_pid, flush_pid;
    logic [PFN_W-1:0] fill_pfn;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    ptag_tlb u_dut (
        .clk(clk), .rst(rst),
        .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_pid(lk_pid),
        .lk_write(lk_write), .lk_off(lk_off),
        .lk_hit(lk_hit), .lk_fault(lk_fault), .lk_paddr(lk_paddr),
        .lk_ref(lk_ref), .lk_mod(lk_mod), .miss_req(miss_req),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_pid(fill_pid),
        .fill_pfn(fill_pfn), .fill_wr_ok(fill_wr_ok), .clr_ref(clr_ref),
        .flush_valid(flush_valid), .flush_all(flush_all), .flush_pid(flush_pid)
    );

    // op: 1 = fill, 0 = lookup
    typedef struct packed {
        logic             op;
        logic [VPN_W-1:0] vpn;
        logic [PID_W-1:0] pid;
        logic             wr;
        logic [OFF_W-1:0] off;
        logic [PFN_W-1:0] pfn;
        logic             wok;
        logic             e_hit;
        logic             e_fault;
        logic             e_ref;
        logic             e_mod;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 36'h100, 8'd1, 1'b0, 12'h000, 28'hAAA, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
        '{1'b1, 36'h100, 8'd2, 1'b0, 12'h000, 28'hBBB, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        '{1'b0, 36'h100, 8'd1, 1'b0, 12'h123, 28'hAAA, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
        '{1'b0, 36'h100, 8'd2, 1'b0, 12'hFFF, 28'hBBB, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
        '{1'b0, 36'h100, 8'd3, 1'b0, 12'h010, 28'h000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        '{1'b0, 36'h101, 8'd1, 1'b0, 12'h010, 28'h000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        '{1'b0, 36'h100, 8'd1, 1'b1, 12'h000, 28'hAAA, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
        '{1'b0, 36'h100, 8'd1, 1'b0, 12'h004, 28'hAAA, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1},
        '{1'b0, 36'h100, 8'd2, 1'b1, 12'h000, 28'h000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
        '{1'b0, 36'h100, 8'd2, 1'b0, 12'h008, 28'hBBB, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0}
    };

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_inputs();
        lk_valid = 0; lk_write = 0; lk_vpn = '0; lk_pid = '0; lk_off = '0;
        fill_valid = 0; fill_vpn = '0; fill_pid = '0; fill_pfn = '0; fill_wr_ok = 0;
        clr_ref = 0; flush_valid = 0; flush_all = 0; flush_pid = '0;
    endtask

    task automatic finish_cycle();
        @(posedge clk);
        #1 clear_inputs();
    endtask

    task automatic do_fill(input logic [VPN_W-1:0] v, input logic [PID_W-1:0] p,
                           input logic [PFN_W-1:0] f, input logic w);
        @(negedge clk);
        fill_valid = 1; fill_vpn = v; fill_pid = p; fill_pfn = f; fill_wr_ok = w;
        finish_cycle();
    endtask

    task automatic do_lookup(input logic [VPN_W-1:0] v, input logic [PID_W-1:0] p,
                             input logic wr, input logic [OFF_W-1:0] o,
                             input logic e_hit, input logic e_fault,
                             input logic [PFN_W-1:0] e_pfn, input logic e_ref,
                             input logic e_mod, input string req);
        @(negedge clk);
        lk_valid = 1; lk_vpn = v; lk_pid = p; lk_write = wr; lk_off = o;
        #1;
        chk(lk_hit == e_hit, {req, " hit"}, 64'(lk_hit), 64'(e_hit));
        chk(lk_fault == e_fault, {req, " fault"}, 64'(lk_fault), 64'(e_fault));
        chk(miss_req == (!e_hit && !e_fault), {req, " miss_req"}, 64'(miss_req), 64'(!e_hit && !e_fault));
        if (e_hit) begin
            chk(lk_paddr == {e_pfn, o}, {req, " paddr"}, 64'(lk_paddr), 64'({e_pfn, o}));
            chk(lk_ref == e_ref, {req, " ref"}, 64'(lk_ref), 64'(e_ref));
            chk(lk_mod == e_mod, {req, " mod"}, 64'(lk_mod), 64'(e_mod));
        end
        finish_cycle();
    endtask

    task automatic probe(input logic [VPN_W-1:0] v, input logic [PID_W-1:0] p,
                         input logic e_hit, input string req);
        @(negedge clk);
        lk_valid = 1; lk_vpn = v; lk_pid = p;
        #1;
        chk(lk_hit == e_hit, req, 64'(lk_hit), 64'(e_hit));
        finish_cycle();
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        clear_inputs();
        rst = 1;
        repeat (3) @(posedge clk);
        #1 rst = 0;

        // R12: empty after reset
        do_lookup(36'h100, 8'd1, 0, 12'h0, 0, 0, '0, 0, 0, "R12 reset empty");

        // table of vectors: R1 R2 R3 R4 R6 R7
        for (int i = 0; i < NV; i++) begin
            if (VECS[i].op)
                do_fill(VECS[i].vpn, VECS[i].pid, VECS[i].pfn, VECS[i].wok);
            else
                do_lookup(VECS[i].vpn, VECS[i].pid, VECS[i].wr, VECS[i].off,
                          VECS[i].e_hit, VECS[i].e_fault, VECS[i].pfn,
                          VECS[i].e_ref, VECS[i].e_mod, $sformatf("R1/R2/R6/R7 vec%0d", i));
        end

        // R5: clear all reference bits
        @(negedge clk); clr_ref = 1; finish_cycle();
        do_lookup(36'h100, 8'd1, 0, 12'h1, 1, 0, 28'hAAA, 0, 1, "R5 ref cleared");
        do_lookup(36'h100, 8'd1, 0, 12'h2, 1, 0, 28'hAAA, 1, 1, "R4 ref set again");

        // R8: refill of present tag overwrites in place, bits fresh
        do_fill(36'h100, 8'd1, 28'hCCC, 1);
        do_lookup(36'h100, 8'd1, 0, 12'h3, 1, 0, 28'hCCC, 0, 0, "R8 in-place refill");
        do_lookup(36'h100, 8'd2, 0, 12'h3, 1, 0, 28'hBBB, 0, 0, "R8 other pid kept");

        // R11: fill and lookup same tag same cycle
        @(negedge clk);
        fill_valid = 1; fill_vpn = 36'h400; fill_pid = 8'd7; fill_pfn = 28'h777; fill_wr_ok = 1;
        lk_valid = 1; lk_vpn = 36'h400; lk_pid = 8'd7;
        #1;
        chk(lk_hit == 0, "R11 collide hit", 64'(lk_hit), 0);
        chk(miss_req == 1, "R11 collide miss", 64'(miss_req), 1);
        finish_cycle();
        do_lookup(36'h400, 8'd7, 0, 12'h5, 1, 0, 28'h777, 0, 0, "R11 visible next cycle");

        // R10: flush by process, then all
        @(negedge clk); flush_valid = 1; flush_pid = 8'd1; finish_cycle();
        probe(36'h100, 8'd1, 0, "R10 pid flushed");
        probe(36'h100, 8'd2, 1, "R10 other pid kept");
        @(negedge clk); flush_valid = 1; flush_all = 1; finish_cycle();
        probe(36'h100, 8'd2, 0, "R10 all flushed");
        probe(36'h400, 8'd7, 0, "R10 all flushed b");

        // R8/R9: replacement (pointer still at 0)
        for (int k = 0; k < 16; k++) do_fill(36'h1000 + k, 8'd5, 28'h500 + k, 1);
        do_fill(36'h2000, 8'd5, 28'h600, 1);          // evicts entry 0
        probe(36'h1000, 8'd5, 0, "R9 clean victim at pointer");
        probe(36'h1001, 8'd5, 1, "R9 keep 1");
        probe(36'h1002, 8'd5, 1, "R9 keep 2");
        do_fill(36'h3000, 8'd5, 28'h601, 1);          // skips 1,2 -> evicts 3
        probe(36'h1003, 8'd5, 0, "R9 skips referenced");
        probe(36'h1001, 8'd5, 1, "R9 referenced kept 1");
        probe(36'h1002, 8'd5, 1, "R9 referenced kept 2");
        probe(36'h2000, 8'd5, 1, "R9 earlier fill kept");
        probe(36'h3000, 8'd5, 1, "R9 new fill present");
        for (int k = 4; k < 16; k++) probe(36'h1000 + k, 8'd5, 1, "R9 mark all");
        do_fill(36'h4000, 8'd5, 28'h602, 1);          // all referenced -> pointer 4
        probe(36'h1004, 8'd5, 0, "R9 all set pointer victim");
        probe(36'h1005, 8'd5, 1, "R9 neighbour kept");
        do_lookup(36'h4000, 8'd5, 0, 12'h9, 1, 0, 28'h602, 0, 0, "R9 pointer fill");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule